// File: doc/BRIEF.md
# Sequential Signed Long-by-Word Divider

This unit divides a two-word signed dividend by a one-word signed divisor over several clock cycles. It returns a one-word quotient and a one-word remainder, with four condition flags: negative (N), zero (Z), overflow (V) and carry (C). It is meant to sit beside a word-oriented processor datapath as its divide execution unit. Operand fetch and result writeback are handled by the surrounding logic.

A one-cycle `start_i` pulse presents the operands. The unit converts both operands to unsigned magnitudes and records their signs. It then doubles the divisor magnitude until it reaches the dividend or its top bit is set. A shift-and-subtract loop follows, one step per clock, and it leaves early once the partial remainder reaches zero. Any outstanding quotient shifts are applied after an early exit. The signs are restored in a final cycle, and `done_o` pulses for one cycle with the results.

Overflow is detected during the loop: the quotient magnitude must stay below half the word range. A zero divisor and a zero dividend are both settled without entering the loop.

Top module: `sdiv_unit`

## Requirements
- R1: The dividend is the two's complement value {dvd_hi_i, dvd_lo_i}, with the high word in bits 31..16. The divisor dvs_i is a 16-bit two's complement value.
- R2: The quotient truncates toward zero and the remainder has the dividend's sign: 4/3 = 1 rem 1, -4/-3 = 1 rem -1, 4/-3 = -1 rem 1, -4/3 = -1 rem -1.
- R3: A zero divisor gives V=1, C=1, N=0, Z=0. `done_o` rises one cycle after start, `busy_o` never rises, and quot_o and rem_o keep their previous values.
- R4: V=1 whenever the unsigned quotient magnitude reaches 32768, which includes a true result of -32768. In that case N=0, Z=0, C=0, and quot_o and rem_o keep their previous values.
- R5: When V=0, N equals bit 15 of quot_o, Z is 1 exactly when quot_o is 0, and C is 0.
- R6: A zero dividend with a nonzero divisor gives quotient 0, remainder 0, Z=1 and N=V=C=0. `done_o` rises one cycle after start and `busy_o` never rises.
- R7: The most negative dividend (-2^31) is converted to the magnitude 2^31 without error. With any nonzero divisor it reports V=1.
- R8: `busy_o` is high from the cycle after an accepted start until the result is ready. `done_o` is high for exactly one cycle and never together with `busy_o`. Result outputs change only in a `done_o` cycle.
- R9: A start pulse while `busy_o` is high is ignored. The running operation completes with its own result and produces no extra `done_o`.
- R10: An exact division whose partial remainder reaches zero before all shifts are used still yields the full quotient (for example 48/3 = 16 rem 0).
- R11: A zero quotient from operands of opposite signs reports Z=1 and N=0 (for example 1/-3 = 0 rem 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; operands sampled with it |
| dvd_hi_i | input | 16 | Dividend high word |
| dvd_lo_i | input | 16 | Dividend low word |
| dvs_i | input | 16 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quot_o | output | 16 | Signed quotient |
| rem_o | output | 16 | Signed remainder |
| flag_n_o | output | 1 | Quotient negative |
| flag_z_o | output | 1 | Quotient zero |
| flag_v_o | output | 1 | Overflow or divide by zero |
| flag_c_o | output | 1 | Divide by zero |

## Verification
The bench builds the unit with the default word width of 16. At that width the full signed 32-bit dividend range is reachable, including -2^31 and 0x7FFFFFFF. Those operands drive the normalize phase to its longest run, up to the divisor's top bit, and they reach the overflow boundary at a quotient magnitude of 32768. At this width the early-exit path with trailing quotient shifts, and the quotient-zero case with opposite signs, both come from small hand-checkable operands.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_NORM = 3'd1,
        PH_LOOP = 3'd2,
        PH_FIX  = 3'd3,
        PH_WRAP = 3'd4
    } phase_e;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0]   dvd_hi,
    input  logic [W-1:0]   dvd_lo,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dvs_mag,
    output logic           dvd_neg,
    output logic           dvs_neg,
    output logic           dvd_zero,
    output logic           dvs_zero
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_full;

    always_comb begin
        dvd_full = {dvd_hi, dvd_lo};
        dvd_neg  = dvd_full[DW-1];
        dvs_neg  = dvs[W-1];
        // -2^(DW-1) maps to 2^(DW-1), which the unsigned width holds
        dvd_mag  = dvd_neg ? (DW'(0) - dvd_full) : dvd_full;
        dvs_mag  = dvs_neg ? (W'(0) - dvs) : dvs;
        dvd_zero = (dvd_full == '0);
        dvs_zero = (dvs == '0);
    end

endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         dvd_neg,
    input  logic         dvs_neg,
    input  logic         ovf,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         flag_n,
    output logic         flag_z
);
    always_comb begin
        quot   = (dvd_neg ^ dvs_neg) ? (W'(0) - q_mag) : q_mag;
        rem    = dvd_neg ? (W'(0) - r_mag) : r_mag;
        flag_n = !ovf && quot[W-1];
        flag_z = !ovf && (quot == '0);
    end

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         flag_n_o,
    output logic         flag_z_o,
    output logic         flag_v_o,
    output logic         flag_c_o
);
    import sdiv_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW) + 1;

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [W-1:0]  q;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          aneg;
        logic          bneg;
        logic [W-1:0]  quot;
        logic [W-1:0]  rem;
        logic          fn;
        logic          fz;
        logic          fv;
        logic          fc;
        logic          done;
    } state_t;

    state_t s_d, s_q;

    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;
    logic          dvd_neg, dvs_neg, dvd_zero, dvs_zero;
    logic [W-1:0]  fix_quot, fix_rem;
    logic          fix_n, fix_z;

    sdiv_prep #(.W(W)) u_prep (
        .dvd_hi   (dvd_hi_i),
        .dvd_lo   (dvd_lo_i),
        .dvs      (dvs_i),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .dvd_neg  (dvd_neg),
        .dvs_neg  (dvs_neg),
        .dvd_zero (dvd_zero),
        .dvs_zero (dvs_zero)
    );

    sdiv_fix #(.W(W)) u_fix (
        .q_mag   (s_q.q),
        .r_mag   (s_q.a[W-1:0]),
        .dvd_neg (s_q.aneg),
        .dvs_neg (s_q.bneg),
        .ovf     (s_q.ovf),
        .quot    (fix_quot),
        .rem     (fix_rem),
        .flag_n  (fix_n),
        .flag_z  (fix_z)
    );

    logic [W-1:0]  step_q;
    logic [DW-1:0] step_a;
    logic          step_ovf;
    logic          step_sub;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        step_q   = {s_q.q[W-2:0], 1'b0};
        step_ovf = s_q.ovf | step_q[W-1];
        step_a   = s_q.a;
        step_sub = (s_q.b <= s_q.a);
        if (step_sub) begin
            step_q   = step_q | W'(1);
            step_ovf = step_ovf | step_q[W-1];
            step_a   = s_q.a - s_q.b;
        end

        case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    if (dvs_zero) begin
                        s_d.fn   = 1'b0;
                        s_d.fz   = 1'b0;
                        s_d.fv   = 1'b1;
                        s_d.fc   = 1'b1;
                        s_d.done = 1'b1;
                    end else if (dvd_zero) begin
                        s_d.quot = '0;
                        s_d.rem  = '0;
                        s_d.fn   = 1'b0;
                        s_d.fz   = 1'b1;
                        s_d.fv   = 1'b0;
                        s_d.fc   = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.a    = dvd_mag;
                        s_d.b    = DW'(dvs_mag);
                        s_d.q    = '0;
                        s_d.cnt  = '0;
                        s_d.ovf  = 1'b0;
                        s_d.aneg = dvd_neg;
                        s_d.bneg = dvs_neg;
                        s_d.ph   = PH_NORM;
                    end
                end
            end
            PH_NORM: begin
                if ((s_q.a > s_q.b) && !s_q.b[DW-1]) begin
                    s_d.b   = {s_q.b[DW-2:0], 1'b0};
                    s_d.cnt = s_q.cnt + CW'(1);
                end else begin
                    s_d.ph = PH_LOOP;
                end
            end
            PH_LOOP: begin
                s_d.q   = step_q;
                s_d.ovf = step_ovf;
                s_d.a   = step_a;
                if (step_sub && (step_a == '0)) begin
                    s_d.ph = PH_FIX;
                end else if (s_q.cnt == '0) begin
                    s_d.ph = PH_WRAP;
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                    s_d.b   = {1'b0, s_q.b[DW-1:1]};
                end
            end
            PH_FIX: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_WRAP;
                end else begin
                    s_d.q   = {s_q.q[W-2:0], 1'b0};
                    s_d.ovf = s_q.ovf | s_q.q[W-2];
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            PH_WRAP: begin
                s_d.ph   = PH_IDLE;
                s_d.done = 1'b1;
                s_d.fn   = fix_n;
                s_d.fz   = fix_z;
                s_d.fv   = s_q.ovf;
                s_d.fc   = 1'b0;
                if (!s_q.ovf) begin
                    s_d.quot = fix_quot;
                    s_d.rem  = fix_rem;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = (s_q.ph != PH_IDLE);
    assign done_o   = s_q.done;
    assign quot_o   = s_q.quot;
    assign rem_o    = s_q.rem;
    assign flag_n_o = s_q.fn;
    assign flag_z_o = s_q.fz;
    assign flag_v_o = s_q.fv;
    assign flag_c_o = s_q.fc;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o); // R8
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R8
    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_d.done |=> ($stable(quot_o) && $stable(rem_o))); // R8
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && dvs_i == '0) |=>
        (done_o && flag_v_o && flag_c_o && !busy_o)); // R3
    AST_C_IMPLIES_V: assert property (@(posedge clk) disable iff (!rst_n)
        flag_c_o |-> flag_v_o); // R3
    AST_NZ_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v_o |-> (!flag_n_o && !flag_z_o)); // R4
    AST_ZERO_DIVIDEND: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && dvs_i != '0 && dvd_hi_i == '0 && dvd_lo_i == '0) |=>
        (done_o && flag_z_o && quot_o == '0 && rem_o == '0)); // R6

endmodule

// File: tb/sdiv_unit_test.sv
module sdiv_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dh = '0, dl = '0, ds = '0;
    logic        busy, done, fn, fz, fv, fc;
    logic [15:0] quot, rem;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dvd_hi_i(dh), .dvd_lo_i(dl), .dvs_i(ds),
        .busy_o(busy), .done_o(done), .quot_o(quot), .rem_o(rem),
        .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
    );

    // {hi, lo, divisor, quotient, remainder, NZVC}
    localparam int NV = 15;
    localparam logic [83:0] VEC [NV] = '{
        {16'h0000, 16'h0004, 16'h0003, 16'h0001, 16'h0001, 4'b0000}, // R2 4/3
        {16'hFFFF, 16'hFFFC, 16'hFFFD, 16'h0001, 16'hFFFF, 4'b0000}, // R2 -4/-3
        {16'h0000, 16'h0004, 16'hFFFD, 16'hFFFF, 16'h0001, 4'b1000}, // R2 4/-3
        {16'hFFFF, 16'hFFFC, 16'h0003, 16'hFFFF, 16'hFFFF, 4'b1000}, // R2 -4/3
        {16'h0000, 16'h0001, 16'hFFFD, 16'h0000, 16'h0001, 4'b0100}, // R11 1/-3
        {16'h0000, 16'h0030, 16'h0003, 16'h0010, 16'h0000, 4'b0000}, // R10 48/3
        {16'h3FFF, 16'h0001, 16'h7FFF, 16'h7FFF, 16'h0000, 4'b0000}, // R5 max fit
        {16'h3FFF, 16'h0001, 16'h8001, 16'h8001, 16'h0000, 4'b1000}, // R5 negative
        {16'h0000, 16'h8000, 16'h0001, 16'h0000, 16'h0000, 4'b0010}, // R4 32768
        {16'hFFFF, 16'h8000, 16'h0001, 16'h0000, 16'h0000, 4'b0010}, // R4 -32768
        {16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'h0000, 4'b0010}, // R7 min/min
        {16'h0001, 16'h86A0, 16'h0007, 16'h37CD, 16'h0005, 4'b0000}, // R1 100000/7
        {16'hFFFE, 16'h7960, 16'h0007, 16'hC833, 16'hFFFB, 4'b1000}, // R1 -100000/7
        {16'h0000, 16'h0005, 16'h0007, 16'h0000, 16'h0005, 4'b0100}, // R11 5/7
        {16'h7FFF, 16'hFFFF, 16'h7FFF, 16'h0000, 16'h0000, 4'b0010}  // R4 long normalize
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] dv, output int lat);
        @(negedge clk);
        start = 1'b1; dh = hi; dl = lo; ds = dv;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog actual=no_done expected=done");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 global watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [15:0] pq, pr;
        repeat (2) @(negedge clk);
        // reset state
        chk("R8 reset busy", {15'd0, busy}, 16'd0);
        chk("R8 reset done", {15'd0, done}, 16'd0);
        chk("R8 reset quot", quot, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            pq = quot; pr = rem;
            run_op(VEC[i][83:68], VEC[i][67:52], VEC[i][51:36], lat);
            chk($sformatf("R1 vec%0d busy_low_at_done", i), {15'd0, busy}, 16'd0);
            chk($sformatf("R5 vec%0d flags NZVC", i), {12'd0, fn, fz, fv, fc}, {12'd0, VEC[i][3:0]});
            if (VEC[i][1]) begin
                chk($sformatf("R4 vec%0d quot held", i), quot, pq);
                chk($sformatf("R4 vec%0d rem held", i), rem, pr);
            end else begin
                chk($sformatf("R2 vec%0d quot", i), quot, VEC[i][35:20]);
                chk($sformatf("R2 vec%0d rem", i), rem, VEC[i][19:4]);
            end
            @(negedge clk);
            chk($sformatf("R8 vec%0d done one cycle", i), {15'd0, done}, 16'd0);
        end

        // R3 divide by zero after a known result
        run_op(16'h0000, 16'h0004, 16'h0003, lat);
        pq = quot; pr = rem;
        run_op(16'h1234, 16'h5678, 16'h0000, lat);
        chk("R3 latency", 16'(lat), 16'd1);
        chk("R3 busy", {15'd0, busy}, 16'd0);
        chk("R3 flags NZVC", {12'd0, fn, fz, fv, fc}, 16'b0011);
        chk("R3 quot held", quot, pq);
        chk("R3 rem held", rem, pr);

        // R6 zero dividend
        run_op(16'h0000, 16'h0000, 16'hFFF9, lat);
        chk("R6 latency", 16'(lat), 16'd1);
        chk("R6 busy", {15'd0, busy}, 16'd0);
        chk("R6 flags NZVC", {12'd0, fn, fz, fv, fc}, 16'b0100);
        chk("R6 quot", quot, 16'd0);
        chk("R6 rem", rem, 16'd0);

        // R9 start while busy is ignored
        @(negedge clk);
        start = 1'b1; dh = 16'h0001; dl = 16'h86A0; ds = 16'h0007;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", {15'd0, busy}, 16'd1);
        repeat (3) @(negedge clk);
        start = 1'b1; dh = 16'h0000; dl = 16'h0004; ds = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 flags NZVC", {12'd0, fn, fz, fv, fc}, 16'b0000);
        chk("R9 quot", quot, 16'h37CD);
        chk("R9 rem", rem, 16'h0005);
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done || busy) lat++;
        end
        chk("R9 no extra activity", 16'(lat), 16'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule